// File: doc/BRIEF.md
# Interrupt Entry/Exit Sequencer

This block is the hardware part of exception handling for a small 32-bit core. It keeps a pending bit for one non-maskable request and for a configurable number of ordinary requests. It picks the most urgent pending request and compares it with the priority of the code that is running. When the request wins, the block saves an eight-word context frame to stack memory and reads the handler address from a vector table. It then pulses a branch strobe to the core. When the core signals a handler return, the block reads the frame back and hands each word to the core for restoration. The core datapath and the memory itself sit outside the block. They are reached through a context input bus, a restore output strobe and a single valid/ready memory port.

Three shortcuts keep latency low. A return that finds a waiting request good enough to run goes straight to that request's vector read, with no unstack and no restack. A more urgent request that arrives while a frame is being saved takes over the vector read that follows, and the earlier request stays pending. A request that arrives while a frame is being restored abandons the restore, rewinds the stack pointer to the still-intact frame and enters the new handler at once.

The controller has four states:
- `ST_RUN`: thread or handler code is executing.
- `ST_PUSH`: the frame is being saved.
- `ST_VFETCH`: the vector table is being read.
- `ST_POP`: the frame is being restored.

The transitions are:
- RUN to PUSH on preemption.
- RUN to VFETCH on a tail-chained return.
- RUN to POP on a plain return.
- PUSH to VFETCH after the eighth write.
- VFETCH to RUN on the vector read, which is also when the handler is entered.
- POP to RUN after the eighth read.
- POP to VFETCH on abandon.

Top module: `exc_sequencer`

## Requirements
- R1: After reset the depth is 0 and the execution priority reads 7, which is the thread level. The stack pointer equals SP_INIT and no memory request is raised.
- R2: The effective priority of the non-maskable request is 0. Ordinary request n has effective priority 1 plus its 2-bit field at irq_prio_i[2n+1:2n]. A lower value is more urgent, and on a tie the lower source number wins. A request preempts only when its effective priority is strictly lower than the execution priority.
- R3: Entry saves eight words, one per accepted beat, as writes at descending addresses. Context word 7 goes to SP-4 first and word 0 goes to SP-32 last, where word k is ctx_i[32k+31:32k]. The stack pointer ends 32 lower than it started.
- R4: After the save, exactly one read is made at VEC_BASE + 4*slot. The slot is 0 for the non-maskable request and n+1 for ordinary request n.
- R5: The vector read completes the entry. At that point branch_o pulses for one cycle with handler_addr_o holding the word read and exc_id_o holding the slot. The depth rises by one and exec_prio_o takes the new handler's effective priority.
- R6: Handlers nest. A more urgent request preempts an active handler, while an equal or less urgent one waits pending with the depth unchanged.
- R7: On return, if no pending request beats the level underneath, the block makes eight reads at ascending addresses from SP. Each read is given to the core as restore_idx_o 0..7 with its data. SP rises by 32, exit_done_o pulses once after the last word, and the depth falls by one.
- R8: On return, if a pending request beats the level underneath, that request is entered with no frame write, no restore and exactly one vector read.
- R9: A more urgent request that arrives during the save does not disturb the eight writes. The vector read that follows is the newer request's, and the older request is entered later.
- R10: A request that beats the level underneath during a restore abandons it. SP returns to the frame base, exit_done_o does not pulse, and the new handler is entered after one vector read.
- R11: A frame write that is held off by mem_ready_i keeps its request, address and data stable until it is accepted.
- R12: A pending bit is set while its input is high and stays set after the input drops. It clears only when that source's vector read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request level |
| irq_i | input | N_IRQ | Ordinary request levels |
| irq_prio_i | input | N_IRQ*PRIO_W | Priority field per ordinary request |
| ctx_i | input | 256 | Eight context words from the core |
| exc_return_i | input | 1 | Handler return strobe from the core |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| branch_o | output | 1 | Handler entry pulse |
| handler_addr_o | output | 32 | Handler address for the branch |
| exc_id_o | output | ID_W | Vector slot of the entered handler |
| exit_done_o | output | 1 | Frame restore complete pulse |
| restore_we_o | output | 1 | Restore word strobe to the core |
| restore_idx_o | output | 3 | Index of the restored context word |
| restore_data_o | output | 32 | Restored context word |
| sp_o | output | 32 | Current stack pointer |
| depth_o | output | DEPTH_W | Number of active handlers |
| exec_prio_o | output | 3 | Current execution priority, 7 for thread |

## Verification
The checks rely on the core keeping to its side of the protocol, so the bench does the same:
- A return strobe is allowed only while the block is running code with at least one handler active. The bench raises it only in a cycle where mem_req_o is low and the depth is non-zero.
- The hold check on frame writes assumes the context words stay stable during a save. The bench drives ctx_i with a fixed pattern for the whole run.
- Request inputs are dropped as soon as the matching entry pulse is seen, or before the return that should tail-chain them. This leaves pending state held only by the latched bits.
- Memory ready is constant in the directed cases and random in the randomized pairs. This exercises stalled beats without breaking the valid/ready rules.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int FRAME_WORDS = 8;
    localparam int FRAME_W     = $clog2(FRAME_WORDS);

    typedef enum logic [1:0] {
        ST_RUN,
        ST_PUSH,
        ST_VFETCH,
        ST_POP
    } seq_state_t;
endpackage

// File: rtl/exc_pend_arb.sv
module exc_pend_arb #(
    parameter  int N_IRQ   = 8,
    parameter  int PRIO_W  = 2,
    localparam int ID_W    = $clog2(N_IRQ + 1),
    localparam int EPRIO_W = PRIO_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nmi_i,
    input  logic [N_IRQ-1:0]        irq_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic                    clr_i,
    input  logic [ID_W-1:0]         clr_id_i,
    output logic                    win_valid_o,
    output logic [ID_W-1:0]         win_id_o,
    output logic [EPRIO_W-1:0]      win_prio_o
);
    localparam int NSRC = N_IRQ + 1;

    logic [NSRC-1:0]    pend_q;
    logic [NSRC-1:0]    req;
    logic [NSRC-1:0]    clr_mask;
    logic [EPRIO_W-1:0] eprio [NSRC];

    assign req = {irq_i, nmi_i};

    // Slot 0 is the non-maskable source; slot g is ordinary request g-1.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign clr_mask[g] = clr_i && (clr_id_i == ID_W'(g));
            if (g == 0) begin : g_nmi
                assign eprio[g] = '0;
            end else begin : g_irq
                assign eprio[g] = EPRIO_W'(irq_prio_i[(g-1)*PRIO_W +: PRIO_W]) + EPRIO_W'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | req) & ~clr_mask;
        end
    end

    // Scan from the highest slot down with <=, so a tie leaves the lower slot.
    always_comb begin
        win_valid_o = 1'b0;
        win_id_o    = '0;
        win_prio_o  = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i] && (!win_valid_o || eprio[i] <= win_prio_o)) begin
                win_valid_o = 1'b1;
                win_id_o    = ID_W'(i);
                win_prio_o  = eprio[i];
            end
        end
    end

    // R2: a pending non-maskable request always owns the arbitration
    p_nmi_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] |-> (win_valid_o && win_id_o == '0 && win_prio_o == '0));

    // R12: a bit leaves the pending set only through a clear
    p_pend_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q[0]) && !$past(clr_mask[0])) |-> pend_q[0]);
endmodule

// File: rtl/exc_act_stack.sv
module exc_act_stack #(
    parameter  int DEPTH   = 5,
    parameter  int EPRIO_W = 3,
    localparam int DW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [EPRIO_W-1:0] push_prio_i,
    input  logic               pop_i,
    output logic [EPRIO_W-1:0] top_prio_o,
    output logic [EPRIO_W-1:0] below_prio_o,
    output logic [DW-1:0]      depth_o
);
    logic [EPRIO_W-1:0] prio_q [DEPTH];
    logic [DW-1:0]      depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_q[i] <= '1;
            end
        end else if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (DW'(i) == depth_q) begin
                    prio_q[i] <= push_prio_i;
                end
            end
            depth_q <= depth_q + DW'(1);
        end else if (pop_i) begin
            depth_q <= depth_q - DW'(1);
        end
    end

    // An empty stack reads as the all-ones thread level.
    always_comb begin
        top_prio_o   = '1;
        below_prio_o = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (DW'(i + 1) == depth_q) begin
                top_prio_o = prio_q[i];
            end
            if (DW'(i + 2) == depth_q) begin
                below_prio_o = prio_q[i];
            end
        end
    end

    assign depth_o = depth_q;

    // R6: strict preemption bounds nesting to one level per priority value
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (depth_q < DW'(DEPTH)));

    // R7: a return never happens with no active handler
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (depth_q != '0 && !push_i));
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_pkg::*;
#(
    parameter  int          N_IRQ    = 8,
    parameter  int          PRIO_W   = 2,
    parameter  logic [31:0] VEC_BASE = 32'h0000_0100,
    parameter  logic [31:0] SP_INIT  = 32'h0000_0400,
    localparam int          ID_W     = $clog2(N_IRQ + 1),
    localparam int          EPRIO_W  = PRIO_W + 1,
    localparam int          NEST     = (2 ** PRIO_W) + 1,
    localparam int          DEPTH_W  = $clog2(NEST + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nmi_i,
    input  logic [N_IRQ-1:0]        irq_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic [FRAME_WORDS*32-1:0] ctx_i,
    input  logic                    exc_return_i,
    output logic                    mem_req_o,
    output logic                    mem_we_o,
    output logic [31:0]             mem_addr_o,
    output logic [31:0]             mem_wdata_o,
    input  logic                    mem_ready_i,
    input  logic [31:0]             mem_rdata_i,
    output logic                    branch_o,
    output logic [31:0]             handler_addr_o,
    output logic [ID_W-1:0]         exc_id_o,
    output logic                    exit_done_o,
    output logic                    restore_we_o,
    output logic [FRAME_W-1:0]      restore_idx_o,
    output logic [31:0]             restore_data_o,
    output logic [31:0]             sp_o,
    output logic [DEPTH_W-1:0]      depth_o,
    output logic [EPRIO_W-1:0]      exec_prio_o
);
    seq_state_t st_q, st_nxt;

    logic               win_valid;
    logic [ID_W-1:0]    win_id;
    logic [EPRIO_W-1:0] win_prio;
    logic [EPRIO_W-1:0] top_prio, below_prio;

    logic [FRAME_W-1:0] cnt_q;
    logic [31:0]        sp_q;
    logic [ID_W-1:0]    sel_id_q;
    logic [EPRIO_W-1:0] sel_prio_q;
    logic               branch_q, exit_q;
    logic [31:0]        handler_q;
    logic [ID_W-1:0]    exc_id_q;

    logic beat, last, preempt, tail, abandon;
    logic stk_push, stk_pop, latch_sel, clr_pend;

    exc_pend_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_i      (nmi_i),
        .irq_i      (irq_i),
        .irq_prio_i (irq_prio_i),
        .clr_i      (clr_pend),
        .clr_id_i   (sel_id_q),
        .win_valid_o(win_valid),
        .win_id_o   (win_id),
        .win_prio_o (win_prio)
    );

    exc_act_stack #(.DEPTH(NEST), .EPRIO_W(EPRIO_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .push_prio_i (sel_prio_q),
        .pop_i       (stk_pop),
        .top_prio_o  (top_prio),
        .below_prio_o(below_prio),
        .depth_o     (depth_o)
    );

    assign beat    = mem_req_o && mem_ready_i;
    assign last    = (cnt_q == FRAME_W'(FRAME_WORDS - 1));
    assign preempt = win_valid && (win_prio < top_prio);
    assign tail    = win_valid && (win_prio < below_prio);
    assign abandon = (st_q == ST_POP) && win_valid && (win_prio < top_prio);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions and control strobes
    always_comb begin
        st_nxt    = st_q;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        latch_sel = 1'b0;
        clr_pend  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (exc_return_i) begin
                    stk_pop = 1'b1;
                    if (tail) begin
                        st_nxt    = ST_VFETCH;
                        latch_sel = 1'b1;
                    end else begin
                        st_nxt = ST_POP;
                    end
                end else if (preempt) begin
                    st_nxt = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (beat && last) begin
                    st_nxt    = ST_VFETCH;
                    latch_sel = 1'b1;
                end
            end
            ST_VFETCH: begin
                if (beat) begin
                    st_nxt   = ST_RUN;
                    stk_push = 1'b1;
                    clr_pend = 1'b1;
                end
            end
            ST_POP: begin
                if (abandon) begin
                    st_nxt    = ST_VFETCH;
                    latch_sel = 1'b1;
                end else if (beat && last) begin
                    st_nxt = ST_RUN;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    // Memory-side and core-side outputs
    always_comb begin
        mem_req_o    = (st_q != ST_RUN);
        mem_we_o     = (st_q == ST_PUSH);
        mem_addr_o   = sp_q;
        mem_wdata_o  = '0;
        restore_we_o = 1'b0;
        unique case (st_q)
            ST_PUSH: begin
                mem_addr_o  = sp_q - 32'd4;
                mem_wdata_o = ctx_i[(FRAME_WORDS - 1 - int'(cnt_q))*32 +: 32];
            end
            ST_VFETCH: mem_addr_o = VEC_BASE + (32'(sel_id_q) << 2);
            ST_POP: begin
                mem_addr_o   = sp_q;
                restore_we_o = beat && !abandon;
            end
            default: mem_addr_o = sp_q;
        endcase
    end

    assign restore_idx_o  = cnt_q;
    assign restore_data_o = mem_rdata_i;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sp_q       <= SP_INIT;
            sel_id_q   <= '0;
            sel_prio_q <= '0;
            branch_q   <= 1'b0;
            exit_q     <= 1'b0;
            handler_q  <= '0;
            exc_id_q   <= '0;
        end else begin
            branch_q <= 1'b0;
            exit_q   <= 1'b0;
            if (st_q == ST_RUN) begin
                cnt_q <= '0;
            end else if (beat && (st_q == ST_PUSH || st_q == ST_POP) && !abandon) begin
                cnt_q <= cnt_q + FRAME_W'(1);
            end
            if (latch_sel) begin
                sel_id_q   <= win_id;
                sel_prio_q <= win_prio;
            end
            if (st_q == ST_PUSH && beat) begin
                sp_q <= sp_q - 32'd4;
            end else if (abandon) begin
                sp_q <= sp_q - (32'(cnt_q) << 2);
            end else if (st_q == ST_POP && beat) begin
                sp_q <= sp_q + 32'd4;
                exit_q <= last;
            end
            if (st_q == ST_VFETCH && beat) begin
                branch_q  <= 1'b1;
                handler_q <= mem_rdata_i;
                exc_id_q  <= sel_id_q;
            end
        end
    end

    assign branch_o       = branch_q;
    assign handler_addr_o = handler_q;
    assign exc_id_o       = exc_id_q;
    assign exit_done_o    = exit_q;
    assign sp_o           = sp_q;
    assign exec_prio_o    = top_prio;

    // R7: the core may only return from a running handler
    p_ret_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_return_i |-> (st_q == ST_RUN && depth_o != '0));

    // R7: exit pulse follows the restore of the last frame word
    p_exit_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_done_o |-> ($past(restore_we_o) && $past(restore_idx_o) == FRAME_W'(FRAME_WORDS - 1)));

    // R11: a stalled frame write holds its beat
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !mem_ready_i) |=>
        (mem_req_o && mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R5: every entry pulse is matched by one more active level
    p_branch_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> (depth_o == $past(depth_o) + DEPTH_W'(1)));

    // R8: a vector read reached straight from running code is a return
    p_tail_from_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_RUN && st_q == ST_VFETCH) |-> $past(exc_return_i));

    // R10: an abandoned restore never reports an exit
    p_abandon_noexit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_POP && st_q == ST_VFETCH) |-> !exit_done_o);
endmodule

// File: tb/exc_sequencer_bench.sv
module exc_sequencer_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          N_IRQ      = 8;
    localparam int          PRIO_W     = 2;
    localparam logic [31:0] VEC_BASE   = 32'h0000_0100;
    localparam logic [31:0] SP_INIT    = 32'h0000_0400;
    localparam int          ID_W       = $clog2(N_IRQ + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi = 1'b0;
    logic [N_IRQ-1:0] irq = '0;
    logic [N_IRQ*PRIO_W-1:0] prio = '1;
    logic [255:0] ctx;
    logic ret = 1'b0;
    logic mem_req, mem_we, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic branch, exit_done, restore_we;
    logic [31:0] handler, restore_data, sp;
    logic [ID_W-1:0] exc_id;
    logic [2:0] restore_idx;
    logic [2:0] depth;
    logic [2:0] exec_prio;

    int n_checks = 0, n_fail = 0, cycles = 0;
    int n_wr, n_rd, n_rs, n_branch, n_exit;
    logic [31:0] wr_addr [16], wr_data [16], rd_addr [16], rs_data [16];
    logic [2:0]  rs_idx [16];
    logic [ID_W-1:0] last_id;
    logic [31:0] last_handler;
    bit rand_ready = 1'b0;
    logic [31:0] mem [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_sequencer #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .VEC_BASE(VEC_BASE), .SP_INIT(SP_INIT))
    u_exc_sequencer (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_i(irq), .irq_prio_i(prio),
        .ctx_i(ctx), .exc_return_i(ret),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
        .branch_o(branch), .handler_addr_o(handler), .exc_id_o(exc_id),
        .exit_done_o(exit_done), .restore_we_o(restore_we), .restore_idx_o(restore_idx),
        .restore_data_o(restore_data), .sp_o(sp), .depth_o(depth), .exec_prio_o(exec_prio)
    );

    function automatic logic [31:0] ctx_word(input int k);
        return 32'hC0DE_0000 + 32'(k);
    endfunction

    function automatic logic [31:0] vec_val(input int slot);
        return 32'h0000_8000 + (32'(slot) << 6);
    endfunction

    function automatic int eff(input int src, input logic [N_IRQ*PRIO_W-1:0] p);
        if (src < 0) return 0;
        return 1 + int'(p[src*PRIO_W +: PRIO_W]);
    endfunction

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // Monitor: sample mid-cycle, then choose next ready
    always @(negedge clk) begin
        cycles++;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (n_wr < 16) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
                n_wr++;
            end else begin
                if (n_rd < 16) rd_addr[n_rd] = mem_addr;
                n_rd++;
            end
        end
        if (restore_we) begin
            if (n_rs < 16) begin rs_idx[n_rs] = restore_idx; rs_data[n_rs] = restore_data; end
            n_rs++;
        end
        if (branch) begin n_branch++; last_id = exc_id; last_handler = handler; end
        if (exit_done) n_exit++;
        mem_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clr_log();
        n_wr = 0; n_rd = 0; n_rs = 0; n_exit = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_branch(input int prev, input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (n_branch != prev) begin got = 1'b1; return; end
            step();
        end
    endtask

    task automatic enter(input int src, input string req);
        int prev;
        bit got;
        prev = n_branch;
        if (src < 0) nmi = 1'b1; else irq[src] = 1'b1;
        wait_branch(prev, 400, got);
        nmi = 1'b0;
        if (src >= 0) irq[src] = 1'b0;
        chk(req, 32'(got), 32'd1);
    endtask

    task automatic do_return();
        int pb, pe;
        while (mem_req || depth == 0) step();
        pb = n_branch; pe = n_exit;
        ret = 1'b1;
        step();
        ret = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (n_branch != pb || n_exit != pe) return;
            step();
        end
        chk("R7 return completes", 32'd0, 32'd1);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) ctx[k*32 +: 32] = ctx_word(k);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int s = 0; s <= N_IRQ; s++) mem[(VEC_BASE >> 2) + s] = vec_val(s);
        void'($urandom(32'd24681));
        n_branch = 0;
        clr_log();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit got;
        int prev;
        repeat (3) step();
        // R1 reset state
        chk("R1 depth", 32'(depth), 32'd0);
        chk("R1 exec_prio", 32'(exec_prio), 32'd7);
        chk("R1 sp", sp, SP_INIT);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        step();

        // R3 R4 R5: single entry of irq3 at prio 2
        prio = '1;
        prio[3*PRIO_W +: PRIO_W] = 2'd2;
        clr_log();
        enter(3, "R5 irq3 entry");
        chk("R5 exc_id", 32'(last_id), 32'd4);
        chk("R5 handler", last_handler, vec_val(4));
        chk("R3 write count", 32'(n_wr), 32'd8);
        chk("R3 first addr", wr_addr[0], SP_INIT - 32'd4);
        chk("R3 first data", wr_data[0], ctx_word(7));
        chk("R3 last addr", wr_addr[7], SP_INIT - 32'd32);
        chk("R3 last data", wr_data[7], ctx_word(0));
        chk("R3 sp", sp, SP_INIT - 32'd32);
        chk("R4 vector addr", rd_addr[0], VEC_BASE + 32'd16);
        chk("R4 read count", 32'(n_rd), 32'd1);
        chk("R5 depth", 32'(depth), 32'd1);
        chk("R5 exec_prio", 32'(exec_prio), 32'd3);
        // R7 R12: pending cleared, so the return restores
        clr_log();
        do_return();
        chk("R12 no re-entry", 32'(n_exit), 32'd1);
        chk("R7 restore count", 32'(n_rs), 32'd8);
        chk("R7 restore idx0", 32'(rs_idx[0]), 32'd0);
        chk("R7 restore data7", rs_data[7], ctx_word(7));
        chk("R7 restore idx7", 32'(rs_idx[7]), 32'd7);
        chk("R7 first pop addr", rd_addr[0], SP_INIT - 32'd32);
        step();
        chk("R7 sp", sp, SP_INIT);
        chk("R7 depth", 32'(depth), 32'd0);
        chk("R7 exec_prio", 32'(exec_prio), 32'd7);

        // R6 nesting, R2 ties and NMI, R8 tail chain
        prio = '1;
        prio[1*PRIO_W +: PRIO_W] = 2'd2;
        prio[5*PRIO_W +: PRIO_W] = 2'd2;
        prio[6*PRIO_W +: PRIO_W] = 2'd1;
        enter(1, "R6 irq1 entry");
        prev = n_branch;
        irq[5] = 1'b1;
        repeat (40) step();
        irq[5] = 1'b0;
        chk("R6 equal prio waits", 32'(n_branch - prev), 32'd0);
        chk("R6 depth unchanged", 32'(depth), 32'd1);
        enter(6, "R6 irq6 preempts");
        chk("R6 nested id", 32'(last_id), 32'd7);
        chk("R6 nested depth", 32'(depth), 32'd2);
        enter(-1, "R2 nmi preempts");
        chk("R2 nmi id", 32'(last_id), 32'd0);
        chk("R2 nmi exec_prio", 32'(exec_prio), 32'd0);
        chk("R6 depth 3", 32'(depth), 32'd3);
        clr_log();
        do_return();
        chk("R7 nmi return exits", 32'(n_exit), 32'd1);
        clr_log();
        do_return();
        chk("R7 irq6 return exits", 32'(n_exit), 32'd1);
        chk("R7 exec after", 32'(exec_prio), 32'd3);
        clr_log();
        prev = n_branch;
        do_return();
        chk("R8 tail entry", 32'(n_branch - prev), 32'd1);
        chk("R8 tail id", 32'(last_id), 32'd6);
        chk("R8 no writes", 32'(n_wr), 32'd0);
        chk("R8 no restores", 32'(n_rs), 32'd0);
        chk("R8 one read", 32'(n_rd), 32'd1);
        chk("R12 latched pending", 32'(depth), 32'd1);
        do_return();

        // R9 late arrival
        prio = '1;
        prio[7*PRIO_W +: PRIO_W] = 2'd3;
        prio[2*PRIO_W +: PRIO_W] = 2'd0;
        clr_log();
        prev = n_branch;
        irq[7] = 1'b1;
        for (int i = 0; i < 100 && n_wr < 3; i++) step();
        irq[2] = 1'b1;
        wait_branch(prev, 400, got);
        irq[2] = 1'b0;
        irq[7] = 1'b0;
        chk("R9 newer id", 32'(last_id), 32'd3);
        chk("R9 eight writes", 32'(n_wr), 32'd8);
        chk("R9 one read", 32'(n_rd), 32'd1);
        clr_log();
        prev = n_branch;
        do_return();
        chk("R9 older entered later", 32'(last_id), 32'd8);
        chk("R9 older tail no writes", 32'(n_wr), 32'd0);
        do_return();

        // R10 abandon during restore
        prio = '1;
        prio[4*PRIO_W +: PRIO_W] = 2'd3;
        enter(4, "R10 irq4 entry");
        clr_log();
        prev = n_branch;
        while (mem_req) step();
        ret = 1'b1;
        step();
        ret = 1'b0;
        for (int i = 0; i < 100 && n_rs < 3; i++) step();
        nmi = 1'b1;
        wait_branch(prev, 400, got);
        nmi = 1'b0;
        chk("R10 nmi entered", 32'(last_id), 32'd0);
        chk("R10 no exit", 32'(n_exit), 32'd0);
        chk("R10 sp rewound", sp, SP_INIT - 32'd32);
        chk("R10 partial restore", 32'(n_rs < 8), 32'd1);
        clr_log();
        do_return();
        chk("R10 frame restored later", 32'(n_rs), 32'd8);
        step();
        chk("R10 sp home", sp, SP_INIT);

        // R2 R6 R8 randomized pairs with memory stalls
        rand_ready = 1'b1;
        for (int it = 0; it < 16; it++) begin
            int a, b;
            bit exp_pre;
            a = int'($urandom % N_IRQ);
            b = int'(($urandom % (N_IRQ - 1)) + 1 + a) % N_IRQ;
            prio = N_IRQ*PRIO_W'($urandom);
            exp_pre = eff(b, prio) < eff(a, prio);
            enter(a, "R2 random entry");
            chk("R2 random id", 32'(last_id), 32'(a + 1));
            prev = n_branch;
            irq[b] = 1'b1;
            wait_branch(prev, 60, got);
            irq[b] = 1'b0;
            chk("R2 preempt decision", 32'(got), 32'(exp_pre));
            if (got) begin
                chk("R6 preempt id", 32'(last_id), 32'(b + 1));
                do_return();
                do_return();
            end else begin
                clr_log();
                prev = n_branch;
                do_return();
                chk("R8 random tail id", 32'(last_id), 32'(b + 1));
                chk("R8 random no writes", 32'(n_wr), 32'd0);
                do_return();
            end
            repeat (2) step();
            chk("R7 random drained", 32'(depth), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule